// File: doc/BRIEF.md
# Parity-Protected Single-Port SRAM

This block wraps a single-port on-chip word memory with one even-parity bit per byte lane. Every write stores the bytes selected by a four-bit byte strobe together with a freshly computed parity bit for each of those bytes, so 8-, 16- and 32-bit stores can be mixed freely. Every read returns the whole 32-bit word and re-checks all four lanes. A mismatch on any lane is reported with the read response, latched into a sticky error flag along with the word address, and can also raise a one-cycle reset request.

The request side is a valid/ready channel. Ready is high in every cycle out of reset, so there is never back-pressure and an access is accepted in the cycle it is presented. A read response comes out exactly one cycle later as a valid-only strobe with no ready, because the block never waits. For fault injection, a test input inverts the parity written for the strobed lanes. A later read of that word then fails on purpose, until those lanes are written again with the test input low.

The storage is a register array inside the block, cleared by reset to all-zero words, which have correct parity.

Top module: `par_sram`

## Requirements
- R1: `req_ready` is high in every cycle out of reset. `rsp_valid` is high in exactly the cycle after a read is accepted, and it stays low after a write.
- R2: A write changes only the byte lanes whose strobe bit is set. Strobe bit i covers data bits 8i+7..8i. The other lanes keep both their data and their parity bit.
- R3: A read returns the complete 32-bit stored word on `rsp_rdata` in the `rsp_valid` cycle, and reflects a write made in the cycle before.
- R4: The stored parity bit of a lane is the XOR of its eight data bits (even parity). A word written with `par_invert` low reads back with `rsp_perr` low.
- R5: When `par_invert` is high during a write, the parity of each strobed lane is stored inverted. A later read of that word has `rsp_perr` high.
- R6: Rewriting lanes with `par_invert` low restores their parity. The read error stays as long as any lane still holds inverted parity.
- R7: `err_flag` goes high the cycle after a response with `rsp_perr` high. It stays high until it is cleared.
- R8: `err_addr` holds the word address of the first failing read since the flag was last clear. Later errors do not overwrite it while the flag is set.
- R9: A high `err_clr` clears `err_flag` on the next cycle. If an error response arrives in the same cycle as the clear, the set wins and its address is captured.
- R10: `rst_req` is a one-cycle pulse in the cycle after an error response, and only if `rst_on_err_en` was high in that response cycle. It is never high for two cycles in a row.
- R11: After reset, every word reads as zero without a parity error, and `err_flag`, `rsp_valid` and `rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted (high whenever out of reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane write strobe |
| par_invert | input | 1 | Store inverted parity on written lanes |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data word |
| rsp_perr | output | 1 | Parity mismatch on the current response |
| rst_on_err_en | input | 1 | Allow a reset request on a parity error |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_flag | output | 1 | Sticky parity error flag |
| err_addr | output | ADDR_W (6) | Word address of the first captured error |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The checker watches the properties that hold in every cycle: ready out of reset, a response only one cycle after a read, the flag setting and staying set, the captured address holding while the flag is set, and the reset pulse having a single-cycle width and a valid cause. Data correctness cannot be written as a single-cycle property. That covers byte-lane merging under mixed strobes, parity inversion and later repair, first-error address capture and the set-wins race against a clear, and these are shown only by the bench's vector table and directed scenarios, which compare read data and error outputs against values worked out from the requirements.

// File: rtl/par_sram_pkg.sv
package par_sram_pkg;
  localparam int BYTE_W = 8;

  function automatic logic even_par(input logic [BYTE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/par_sram_gen.sv
module par_sram_gen #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  input  logic                    invert,
  output logic [LANES-1:0]        par
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign par[l] = (^data[l*LANE_W +: LANE_W]) ^ invert;
  end
endmodule

// File: rtl/par_sram_check.sv
module par_sram_check #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data,
  input  logic [LANES-1:0]        par,
  output logic [LANES-1:0]        lane_err,
  output logic                    any_err
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_err[l] = (^data[l*LANE_W +: LANE_W]) != par[l];
  end
  assign any_err = |lane_err;
endmodule

// File: rtl/par_sram_array.sv
module par_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wpar,
  input  logic [LANES-1:0]        strb,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rpar
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic              lane_par [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic              rp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < DEPTH; w++) begin
          lane_mem[w] <= '0;
          lane_par[w] <= 1'b0;
        end
        rd_q <= '0;
        rp_q <= 1'b0;
      end else begin
        if (wr_en && strb[l]) begin
          lane_mem[addr] <= wdata[l*LANE_W +: LANE_W];
          lane_par[addr] <= wpar[l];
        end
        if (rd_en) begin
          rd_q <= lane_mem[addr];
          rp_q <= lane_par[addr];
        end
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_q;
    assign rpar[l]                   = rp_q;
  end
endmodule

// File: rtl/par_sram_err.sv
module par_sram_err #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              detect,
  input  logic [ADDR_W-1:0] det_addr,
  input  logic              clr,
  input  logic              rst_en,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr,
  output logic              rst_req
);
  logic capture;
  assign capture = detect && (!err_flag || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_addr <= '0;
      rst_req  <= 1'b0;
    end else begin
      if (capture) err_addr <= det_addr;
      if (detect)   err_flag <= 1'b1;
      else if (clr) err_flag <= 1'b0;
      rst_req <= detect && rst_en && !rst_req;
    end
  end
endmodule

// File: rtl/par_sram.sv
module par_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [LANES*par_sram_pkg::BYTE_W-1:0] req_wdata,
  input  logic [LANES-1:0]                req_strb,
  input  logic                            par_invert,
  output logic                            rsp_valid,
  output logic [LANES*par_sram_pkg::BYTE_W-1:0] rsp_rdata,
  output logic                            rsp_perr,
  input  logic                            rst_on_err_en,
  input  logic                            err_clr,
  output logic                            err_flag,
  output logic [ADDR_W-1:0]               err_addr,
  output logic                            rst_req
);
  import par_sram_pkg::*;
  localparam int DATA_W = LANES * BYTE_W;

  logic              wr_fire, rd_fire;
  logic [LANES-1:0]  wpar, rpar, lane_err;
  logic              any_err;
  logic [ADDR_W-1:0] rd_addr_q;

  assign req_ready = rst_n;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;

  par_sram_gen #(.LANES(LANES), .LANE_W(BYTE_W)) u_gen (
    .data(req_wdata), .invert(par_invert), .par(wpar)
  );

  par_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(BYTE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .rd_en(rd_fire),
    .addr(req_addr), .wdata(req_wdata), .wpar(wpar), .strb(req_strb),
    .rdata(rsp_rdata), .rpar(rpar)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rd_addr_q <= req_addr;
    end
  end

  par_sram_check #(.LANES(LANES), .LANE_W(BYTE_W)) u_check (
    .data(rsp_rdata), .par(rpar), .lane_err(lane_err), .any_err(any_err)
  );

  assign rsp_perr = rsp_valid && any_err;

  par_sram_err #(.ADDR_W(ADDR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .detect(rsp_perr), .det_addr(rd_addr_q),
    .clr(err_clr), .rst_en(rst_on_err_en),
    .err_flag(err_flag), .err_addr(err_addr), .rst_req(rst_req)
  );

  logic unused_ok;
  assign unused_ok = ^{lane_err, DATA_W[0]};
endmodule

// File: rtl/par_sram_chk.sv
module par_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_perr,
  input logic              rst_on_err_en,
  input logic              err_clr,
  input logic              err_flag,
  input logic [ADDR_W-1:0] err_addr,
  input logic              rst_req
);
  a_r1_ready_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
  a_r1_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r1_no_rsp_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_write) |=> !rsp_valid);
  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perr) |=> err_flag);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rsp_perr) |=> !err_flag);
  a_r8_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> $stable(err_addr));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r10_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(rsp_perr && rst_on_err_en));
endmodule

bind par_sram par_sram_chk #(.ADDR_W(ADDR_W)) u_par_sram_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_perr(rsp_perr),
  .rst_on_err_en(rst_on_err_en), .err_clr(err_clr), .err_flag(err_flag),
  .err_addr(err_addr), .rst_req(rst_req)
);

// File: tb/par_sram_bench.sv
module par_sram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, par_invert = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        rst_on_err_en = 1'b0, err_clr = 1'b0;
  logic        req_ready, rsp_valid, rsp_perr, err_flag, rst_req;
  logic [31:0] rsp_rdata;
  logic [5:0]  err_addr;

  int n_checks = 0, n_fail = 0, n_pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  par_sram u_par_sram (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_strb(req_strb), .par_invert(par_invert), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr), .rst_on_err_en(rst_on_err_en),
    .err_clr(err_clr), .err_flag(err_flag), .err_addr(err_addr), .rst_req(rst_req)
  );

  always @(posedge clk) if (rst_req) n_pulses++;

  // {write, invert, strb[3:0], addr[5:0], wdata[31:0], exp_rdata[31:0], exp_perr}
  localparam int NV = 17;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'hF, 6'd3,  32'h12345678, 32'h0,        1'b0},
    {1'b0, 1'b0, 4'h0, 6'd3,  32'h0,        32'h12345678, 1'b0}, // R3 R4
    {1'b1, 1'b0, 4'h2, 6'd3,  32'hFFFFAAFF, 32'h0,        1'b0},
    {1'b0, 1'b0, 4'h0, 6'd3,  32'h0,        32'h1234AA78, 1'b0}, // R2 byte
    {1'b1, 1'b0, 4'hC, 6'd5,  32'hBEEF1111, 32'h0,        1'b0},
    {1'b0, 1'b0, 4'h0, 6'd5,  32'h0,        32'hBEEF0000, 1'b0}, // R2 half
    {1'b1, 1'b1, 4'hF, 6'd7,  32'h0F0F0F0F, 32'h0,        1'b0},
    {1'b0, 1'b0, 4'h0, 6'd7,  32'h0,        32'h0F0F0F0F, 1'b1}, // R5
    {1'b1, 1'b0, 4'h1, 6'd7,  32'h000000FF, 32'h0,        1'b0},
    {1'b0, 1'b0, 4'h0, 6'd7,  32'h0,        32'h0F0F0FFF, 1'b1}, // R6 partial
    {1'b1, 1'b0, 4'hE, 6'd7,  32'h11223300, 32'h0,        1'b0},
    {1'b0, 1'b0, 4'h0, 6'd7,  32'h0,        32'h112233FF, 1'b0}, // R6 repaired
    {1'b0, 1'b0, 4'h0, 6'd0,  32'h0,        32'h00000000, 1'b0}, // R11
    {1'b1, 1'b1, 4'h1, 6'd63, 32'h00000000, 32'h0,        1'b0},
    {1'b0, 1'b0, 4'h0, 6'd63, 32'h0,        32'h00000000, 1'b1}, // R5 top addr
    {1'b1, 1'b0, 4'hF, 6'd63, 32'h80000001, 32'h0,        1'b0},
    {1'b0, 1'b0, 4'h0, 6'd63, 32'h0,        32'h80000001, 1'b0}  // R4
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the response visible.
  task automatic access(input bit wr, input bit inv, input logic [3:0] strb,
                        input logic [5:0] addr, input logic [31:0] wd);
    req_valid = 1'b1; req_write = wr; par_invert = inv;
    req_strb = strb; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; par_invert = 1'b0; req_strb = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!err_flag && !rsp_valid && !rst_req, "R11", {29'd0, err_flag, rsp_valid, rst_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", {31'd0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      v = VEC[i];
      access(v[76], v[75], v[74:71], v[70:65], v[64:33]);
      if (v[76]) begin
        check(rsp_valid == 1'b0, "R1", {31'd0, rsp_valid}, 32'd0);
      end else begin
        check(rsp_valid == 1'b1, "R1", {31'd0, rsp_valid}, 32'd1);
        check(rsp_rdata == v[32:1], "R3", rsp_rdata, v[32:1]);
        check(rsp_perr == v[0], "R5", {31'd0, rsp_perr}, {31'd0, v[0]});
      end
    end
    @(negedge clk);

    // R7/R8: flag sticky, address of first failure (7) kept over later one (63)
    check(err_flag == 1'b1, "R7", {31'd0, err_flag}, 32'd1);
    check(err_addr == 6'd7, "R8", {26'd0, err_addr}, 32'd7);
    // R10: enable low during all table errors -> no pulse
    check(n_pulses == 0, "R10", n_pulses, 32'd0);

    // R9: clear
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check(err_flag == 1'b0, "R9", {31'd0, err_flag}, 32'd0);

    // R10: reset request pulse with enable set
    rst_on_err_en = 1'b1;
    access(1'b1, 1'b1, 4'h8, 6'd10, 32'h01000000);
    access(1'b0, 1'b0, 4'h0, 6'd10, 32'h0);
    check(rsp_perr == 1'b1, "R5", {31'd0, rsp_perr}, 32'd1);
    @(negedge clk);
    check(rst_req == 1'b1, "R10", {31'd0, rst_req}, 32'd1);
    check(err_addr == 6'd10, "R8", {26'd0, err_addr}, 32'd10);
    @(negedge clk);
    check(rst_req == 1'b0, "R10", {31'd0, rst_req}, 32'd0);
    rst_on_err_en = 1'b0;

    // R9: clear and new error in the same cycle -> set wins, new address
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check(err_flag == 1'b0, "R9", {31'd0, err_flag}, 32'd0);
    access(1'b1, 1'b1, 4'h4, 6'd20, 32'h00330000);
    access(1'b0, 1'b0, 4'h0, 6'd21, 32'h0);      // clean read sets flag? no
    access(1'b0, 1'b0, 4'h0, 6'd20, 32'h0);      // now in error response cycle
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    check(err_flag == 1'b1, "R9", {31'd0, err_flag}, 32'd1);
    check(err_addr == 6'd20, "R9", {26'd0, err_addr}, 32'd20);
    check(rst_req == 1'b0, "R10", {31'd0, rst_req}, 32'd0);
    check(n_pulses == 1, "R10", n_pulses, 32'd1);

    finish_run();
  end
endmodule